// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment-relative memory reference into a linear address. It keeps one cached descriptor for each segment register: the selector last loaded, a 32-bit base, a 20-bit limit and a five-bit attribute field. It writes that cache through a load port. On every request it reads the descriptor of the named segment register, forms the address and decides whether the access is legal. The address and a fault flag appear one clock later.

In protected mode the offset is added to the cached base modulo 2^32. The offset is also checked against the effective limit, which is scaled by granularity and reversed for expand-down data segments, and the access kind is checked against the type bits. In real mode the cached selector, shifted left by four, is added to the low 16 bits of the offset. The sum wraps at 20 bits, and no limit or type check is made. The linear address is used directly as the physical address; there is no page translation.

Attribute encoding on the load port: bit 0 granularity, bit 1 default/big, bit 2 code (1) or data (0), bit 3 expand-down for data (conforming for code), bit 4 write-enable for data (read-enable for code). Access kind encoding: 0 read, 1 write, 2 fetch, 3 reserved.

Top module: `sla_linear_gen`

## Requirements
- R1: After reset `out_valid`, `fault` and `lin_addr` are 0. Every cached descriptor is cleared to all-zero fields, so in protected mode a read at offset 0 through an unloaded segment does not fault and a read at offset 1 faults.
- R2: A request sampled with `req_valid` high at a rising edge produces `out_valid` high, with its `lin_addr` and `fault`, after that same edge. A cycle with no request gives `out_valid` and `fault` low at the next edge.
- R3: In protected mode `lin_addr` is the cached base plus the 32-bit offset modulo 2^32 (base 0FFFF1000h with offset 22h gives 0FFFF1022h). The address is reported even when the access faults.
- R4: In real mode `lin_addr` is {12'b0, (selector*16 + offset[15:0]) mod 2^20}, offset bits 31:16 are ignored, and no limit or type fault is raised.
- R5: The effective limit is the 20-bit limit when attribute bit 0 is 0, and {limit, 12'hFFF} when it is 1. For a non-expand-down segment, an offset above the effective limit faults in protected mode.
- R6: For a data segment with attribute bit 3 set, an offset at or below the effective limit faults. So does an offset above FFFFh when attribute bit 1 is 0, or above FFFFFFFFh when it is 1.
- R7: In protected mode a write to a data segment whose attribute bit 4 is 0 faults, and a read from it does not.
- R8: In protected mode any write to a code segment faults. A read from a code segment faults when attribute bit 4 is 0. A fetch from a code segment never faults on type.
- R9: In protected mode a fetch from a data segment faults, and the reserved access kind 3 faults on any segment.
- R10: A request naming a segment number of NUM_SEGS (6) or above faults in both modes.
- R11: A descriptor load takes effect at the edge that samples it. A request sampled at that same edge for the same segment still uses the previous descriptor, and the next request uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Write one cached descriptor |
| ld_seg | input | 3 | Segment register to write |
| ld_sel | input | 16 | Selector value to cache |
| ld_base | input | 32 | Segment base |
| ld_limit | input | 20 | Raw segment limit |
| ld_attr | input | 5 | Attribute bits (encoding above) |
| req_valid | input | 1 | Address request present |
| req_seg | input | 3 | Segment register used by the access |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| prot_mode | input | 1 | 1 protected mode, 0 real mode |
| out_valid | output | 1 | Result present |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Access violates limit, type or segment number |

## Verification
A wrong cached descriptor field can show up in three ways: as a wrong `lin_addr`, as a missed fault, or as a spurious fault. It appears on the first request that names the corrupted segment, one cycle after that request. A slip in the load-versus-request ordering shows up as an address built from the new base on the very cycle of the load. A limit scaled or compared the wrong way shows up only at the edges of a segment. For that reason the directed cases sit exactly on, and one past, each effective bound.

// File: rtl/sla_pkg.sv
package sla_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // Attribute field as carried on the load port, MSB first
    typedef struct packed {
        logic perm;   // bit 4: writable data / readable code
        logic ext;    // bit 3: expand-down data / conforming code
        logic code;   // bit 2: code segment
        logic big;    // bit 1: default/big
        logic gran;   // bit 0: limit in 4 KB units
    } seg_attr_t;

    localparam int unsigned ATTR_W = $bits(seg_attr_t);

endpackage

// File: rtl/sla_desc_cache.sv
module sla_desc_cache
    import sla_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    parameter int SEG_W    = 3,
    parameter int SEL_W    = 16,
    parameter int BASE_W   = 32,
    parameter int LIM_W    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  seg_attr_t         wr_attr,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic              rd_hit,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output seg_attr_t         rd_attr
);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        seg_attr_t         attr;
    } entry_t;

    localparam logic [SEG_W:0] SEG_CNT = (SEG_W+1)'(NUM_SEGS);

    entry_t tab_q [NUM_SEGS];
    entry_t tab_d [NUM_SEGS];
    entry_t rd_ent;
    logic   wr_ok;

    assign wr_ok  = wr_en && ({1'b0, wr_idx} < SEG_CNT);
    assign rd_hit = {1'b0, rd_idx} < SEG_CNT;

    always_comb begin
        for (int i = 0; i < NUM_SEGS; i++) begin
            tab_d[i] = tab_q[i];
        end
        if (wr_ok) begin
            tab_d[wr_idx] = {wr_sel, wr_base, wr_limit, wr_attr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SEGS; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SEGS; i++) begin
                tab_q[i] <= tab_d[i];
            end
        end
    end

    // Read sees the registered table: a same-edge write is not visible yet
    always_comb begin
        rd_ent = '0;
        if (rd_hit) begin
            rd_ent = tab_q[rd_idx];
        end
    end

    assign rd_sel   = rd_ent.sel;
    assign rd_base  = rd_ent.base;
    assign rd_limit = rd_ent.limit;
    assign rd_attr  = rd_ent.attr;

endmodule

// File: rtl/sla_limit_chk.sv
module sla_limit_chk #(
    parameter int OFF_W   = 32,
    parameter int LIM_W   = 20,
    parameter int SMALL_W = 16
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LIM_W-1:0] limit,
    input  logic             gran,
    input  logic             big,
    input  logic             down,
    output logic             outside
);

    localparam int GRAN_SH = OFF_W - LIM_W;

    logic [OFF_W-1:0] eff_lim;
    logic [OFF_W-1:0] top_bound;

    always_comb begin
        if (gran) begin
            eff_lim = {limit, {GRAN_SH{1'b1}}};
        end else begin
            eff_lim = {{GRAN_SH{1'b0}}, limit};
        end

        if (big) begin
            top_bound = '1;
        end else begin
            top_bound = {{(OFF_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
        end

        if (down) begin
            outside = (off <= eff_lim) || (off > top_bound);
        end else begin
            outside = off > eff_lim;
        end
    end

endmodule

// File: rtl/sla_perm_chk.sv
module sla_perm_chk
    import sla_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       is_code,
    input  logic       perm,
    output logic       deny
);

    acc_kind_e k;

    assign k = acc_kind_e'(kind);

    always_comb begin
        unique case (k)
            ACC_READ:  deny = is_code && !perm;
            ACC_WRITE: deny = is_code || !perm;
            ACC_FETCH: deny = !is_code;
            default:   deny = 1'b1;
        endcase
    end

endmodule

// File: rtl/sla_addr_form.sv
module sla_addr_form #(
    parameter int OFF_W    = 32,
    parameter int SEL_W    = 16,
    parameter int RM_SHIFT = 4,
    parameter int SMALL_W  = 16
) (
    input  logic             prot,
    input  logic [OFF_W-1:0] base,
    input  logic [SEL_W-1:0] sel,
    input  logic [OFF_W-1:0] off,
    output logic [OFF_W-1:0] addr
);

    localparam int REAL_W = SEL_W + RM_SHIFT;

    logic [REAL_W-1:0] seg_part;
    logic [REAL_W-1:0] off_part;
    logic [REAL_W-1:0] real_sum;

    assign seg_part = {sel, {RM_SHIFT{1'b0}}};
    assign off_part = {{(REAL_W-SMALL_W){1'b0}}, off[SMALL_W-1:0]};
    assign real_sum = seg_part + off_part;

    always_comb begin
        if (prot) begin
            addr = base + off;
        end else begin
            addr = {{(OFF_W-REAL_W){1'b0}}, real_sum};
        end
    end

endmodule

// File: rtl/sla_linear_gen.sv
module sla_linear_gen
    import sla_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    parameter int SEL_W    = 16,
    parameter int OFF_W    = 32,
    parameter int LIM_W    = 20,
    parameter int RM_SHIFT = 4,
    parameter int SMALL_W  = 16,
    localparam int SEG_W   = $clog2(NUM_SEGS),
    localparam int REAL_W  = SEL_W + RM_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [OFF_W-1:0]  ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    input  logic [ATTR_W-1:0] ld_attr,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_kind,
    input  logic              prot_mode,
    output logic              out_valid,
    output logic [OFF_W-1:0]  lin_addr,
    output logic              fault
);

    typedef struct packed {
        logic             vld;
        logic             flt;
        logic [OFF_W-1:0] addr;
    } res_t;

    res_t res_d;
    res_t res_q;

    logic             hit_w;
    logic [SEL_W-1:0] sel_w;
    logic [OFF_W-1:0] base_w;
    logic [LIM_W-1:0] limit_w;
    seg_attr_t        attr_w;
    logic             outside_w;
    logic             deny_w;
    logic [OFF_W-1:0] addr_w;

    sla_desc_cache #(
        .NUM_SEGS (NUM_SEGS),
        .SEG_W    (SEG_W),
        .SEL_W    (SEL_W),
        .BASE_W   (OFF_W),
        .LIM_W    (LIM_W)
    ) i_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_valid),
        .wr_idx   (ld_seg),
        .wr_sel   (ld_sel),
        .wr_base  (ld_base),
        .wr_limit (ld_limit),
        .wr_attr  (seg_attr_t'(ld_attr)),
        .rd_idx   (req_seg),
        .rd_hit   (hit_w),
        .rd_sel   (sel_w),
        .rd_base  (base_w),
        .rd_limit (limit_w),
        .rd_attr  (attr_w)
    );

    sla_limit_chk #(
        .OFF_W   (OFF_W),
        .LIM_W   (LIM_W),
        .SMALL_W (SMALL_W)
    ) i_limit (
        .off     (req_off),
        .limit   (limit_w),
        .gran    (attr_w.gran),
        .big     (attr_w.big),
        .down    (attr_w.ext && !attr_w.code),
        .outside (outside_w)
    );

    sla_perm_chk i_perm (
        .kind    (req_kind),
        .is_code (attr_w.code),
        .perm    (attr_w.perm),
        .deny    (deny_w)
    );

    sla_addr_form #(
        .OFF_W    (OFF_W),
        .SEL_W    (SEL_W),
        .RM_SHIFT (RM_SHIFT),
        .SMALL_W  (SMALL_W)
    ) i_addr (
        .prot (prot_mode),
        .base (base_w),
        .sel  (sel_w),
        .off  (req_off),
        .addr (addr_w)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = req_valid;
        res_d.flt = 1'b0;
        if (req_valid) begin
            res_d.addr = addr_w;
            if (!hit_w) begin
                res_d.flt = 1'b1;
            end else if (prot_mode) begin
                res_d.flt = outside_w || deny_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign fault     = res_q.flt;
    assign lin_addr  = res_q.addr;

endmodule

// File: rtl/sla_linear_gen_chk.sv
module sla_linear_gen_chk #(
    parameter int NUM_SEGS = 6,
    parameter int OFF_W    = 32,
    parameter int REAL_W   = 20,
    localparam int SEG_W   = $clog2(NUM_SEGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic             prot_mode,
    input logic             out_valid,
    input logic             fault,
    input logic [OFF_W-1:0] lin_addr
);

    localparam logic [SEG_W:0] SEG_CNT = (SEG_W+1)'(NUM_SEGS);

    logic seg_bad;
    assign seg_bad = {1'b0, req_seg} >= SEG_CNT;

    AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2

    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R2

    AST_FAULT_ONLY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !fault); // R2

    AST_BAD_SEGMENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_bad) |=> fault); // R10

    AST_REAL_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode && !seg_bad) |=> !fault); // R4

    AST_REAL_ADDR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_mode) |=> (lin_addr[OFF_W-1:REAL_W] == '0)); // R4

endmodule

bind sla_linear_gen sla_linear_gen_chk #(
    .NUM_SEGS (NUM_SEGS),
    .OFF_W    (OFF_W),
    .REAL_W   (REAL_W)
) i_sla_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .prot_mode (prot_mode),
    .out_valid (out_valid),
    .fault     (fault),
    .lin_addr  (lin_addr)
);

// File: tb/test_sla_linear_gen.sv
`timescale 1ns/1ps
module test_sla_linear_gen;

    localparam logic [4:0] A_G    = 5'h01;
    localparam logic [4:0] A_B    = 5'h02;
    localparam logic [4:0] A_CODE = 5'h04;
    localparam logic [4:0] A_EXT  = 5'h08;
    localparam logic [4:0] A_PERM = 5'h10;
    localparam logic [1:0] K_RD   = 2'd0;
    localparam logic [1:0] K_WR   = 2'd1;
    localparam logic [1:0] K_FE   = 2'd2;
    localparam logic [1:0] K_RSV  = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic [31:0] ld_base = '0;
    logic [19:0] ld_limit = '0;
    logic [4:0]  ld_attr = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [31:0] req_off = '0;
    logic [1:0]  req_kind = '0;
    logic        prot_mode = 1'b0;
    logic        out_valid;
    logic [31:0] lin_addr;
    logic        fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sla_linear_gen i_sla_linear_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_seg    (ld_seg),
        .ld_sel    (ld_sel),
        .ld_base   (ld_base),
        .ld_limit  (ld_limit),
        .ld_attr   (ld_attr),
        .req_valid (req_valid),
        .req_seg   (req_seg),
        .req_off   (req_off),
        .req_kind  (req_kind),
        .prot_mode (prot_mode),
        .out_valid (out_valid),
        .lin_addr  (lin_addr),
        .fault     (fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] seg, input logic [15:0] sel, input logic [31:0] base,
                        input logic [19:0] lim, input logic [4:0] attr);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = seg; ld_sel = sel; ld_base = base; ld_limit = lim; ld_attr = attr;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Drive one request; the result is registered at the next edge and sampled after it
    task automatic access(input string tag, input logic prot, input logic [2:0] seg,
                          input logic [31:0] off, input logic [1:0] kind,
                          input logic [31:0] exp_addr, input logic exp_fault, input bit chk_addr);
        @(negedge clk);
        req_valid = 1'b1; prot_mode = prot; req_seg = seg; req_off = off; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
        check({tag, " fault"}, {31'b0, fault}, {31'b0, exp_fault});
        if (chk_addr) check({tag, " addr"}, lin_addr, exp_addr);
    endtask

    task automatic t_reset;
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset fault", {31'b0, fault}, 32'd0);
        check("R1 reset addr", lin_addr, 32'd0);
        access("R1 empty desc off0", 1'b1, 3'd0, 32'h0, K_RD, 32'h0, 1'b0, 1'b1);
        access("R1 empty desc off1", 1'b1, 3'd0, 32'h1, K_RD, 32'h1, 1'b1, 1'b1);
    endtask

    task automatic t_latency;
        access("R2 one request", 1'b1, 3'd0, 32'h0, K_RD, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 idle valid", {31'b0, out_valid}, 32'd0);
        check("R2 idle fault", {31'b0, fault}, 32'd0);
    endtask

    task automatic t_prot_addr;
        load(3'd3, 16'h0018, 32'hFFFF_1000, 20'hFFFFF, A_G | A_PERM);
        access("R3 vector", 1'b1, 3'd3, 32'h22, K_RD, 32'hFFFF_1022, 1'b0, 1'b1);
        load(3'd4, 16'h0020, 32'hFFFF_F000, 20'hFFFFF, A_G | A_PERM);
        access("R3 wrap", 1'b1, 3'd4, 32'h2000, K_WR, 32'h0000_1000, 1'b0, 1'b1);
    endtask

    task automatic t_real;
        access("R4 sel18", 1'b0, 3'd3, 32'h22, K_RD, 32'h0000_01A2, 1'b0, 1'b1);
        access("R4 high off ignored", 1'b0, 3'd3, 32'h1234_0010, K_RD, 32'h0000_0190, 1'b0, 1'b1);
        load(3'd5, 16'hFFFF, 32'h0, 20'h0, 5'h00);
        access("R4 20-bit wrap no type fault", 1'b0, 3'd5, 32'h0000_FFFF, K_WR, 32'h0000_FFEF, 1'b0, 1'b1);
    endtask

    task automatic t_gran;
        load(3'd1, 16'h0008, 32'h0000_1000, 20'h00FFF, A_PERM);
        access("R5 byte at limit", 1'b1, 3'd1, 32'hFFF, K_RD, 32'h0000_1FFF, 1'b0, 1'b1);
        access("R5 byte past limit", 1'b1, 3'd1, 32'h1000, K_RD, 32'h0000_2000, 1'b1, 1'b1);
        load(3'd1, 16'h0008, 32'h0, 20'h00001, A_G | A_PERM);
        access("R5 page at limit", 1'b1, 3'd1, 32'h1FFF, K_RD, 32'h0000_1FFF, 1'b0, 1'b1);
        access("R5 page past limit", 1'b1, 3'd1, 32'h2000, K_RD, 32'h0000_2000, 1'b1, 1'b1);
    endtask

    task automatic t_down;
        load(3'd2, 16'h0010, 32'h0, 20'h00FFF, A_EXT | A_PERM);
        access("R6 small at limit", 1'b1, 3'd2, 32'hFFF, K_RD, 32'hFFF, 1'b1, 1'b0);
        access("R6 small above limit", 1'b1, 3'd2, 32'h1000, K_RD, 32'h1000, 1'b0, 1'b1);
        access("R6 small top", 1'b1, 3'd2, 32'hFFFF, K_WR, 32'hFFFF, 1'b0, 1'b0);
        access("R6 small past top", 1'b1, 3'd2, 32'h10000, K_RD, 32'h10000, 1'b1, 1'b0);
        load(3'd2, 16'h0010, 32'h0, 20'h00FFF, A_EXT | A_PERM | A_B);
        access("R6 big past 64K", 1'b1, 3'd2, 32'h10000, K_RD, 32'h10000, 1'b0, 1'b0);
        access("R6 big top", 1'b1, 3'd2, 32'hFFFF_FFFF, K_RD, 32'hFFFF_FFFF, 1'b0, 1'b1);
        access("R6 big below limit", 1'b1, 3'd2, 32'h800, K_RD, 32'h800, 1'b1, 1'b0);
    endtask

    task automatic t_readonly;
        load(3'd1, 16'h0028, 32'h0, 20'hFFFFF, A_G);
        access("R7 write ro", 1'b1, 3'd1, 32'h10, K_WR, 32'h10, 1'b1, 1'b0);
        access("R7 read ro", 1'b1, 3'd1, 32'h10, K_RD, 32'h10, 1'b0, 1'b0);
    endtask

    task automatic t_code;
        load(3'd0, 16'h0030, 32'h0010_0000, 20'hFFFFF, A_G | A_CODE);
        access("R8 read exec-only", 1'b1, 3'd0, 32'h40, K_RD, 32'h0010_0040, 1'b1, 1'b1);
        access("R8 fetch exec-only", 1'b1, 3'd0, 32'h40, K_FE, 32'h0010_0040, 1'b0, 1'b1);
        access("R8 write exec-only", 1'b1, 3'd0, 32'h40, K_WR, 32'h0, 1'b1, 1'b0);
        load(3'd0, 16'h0030, 32'h0010_0000, 20'hFFFFF, A_G | A_CODE | A_PERM);
        access("R8 read readable", 1'b1, 3'd0, 32'h40, K_RD, 32'h0, 1'b0, 1'b0);
        access("R8 write readable", 1'b1, 3'd0, 32'h40, K_WR, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_kind;
        access("R9 fetch data", 1'b1, 3'd3, 32'h22, K_FE, 32'h0, 1'b1, 1'b0);
        access("R9 reserved kind", 1'b1, 3'd3, 32'h22, K_RSV, 32'h0, 1'b1, 1'b0);
        access("R9 reserved kind code", 1'b1, 3'd0, 32'h22, K_RSV, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_badseg;
        access("R10 seg6 prot", 1'b1, 3'd6, 32'h0, K_RD, 32'h0, 1'b1, 1'b0);
        access("R10 seg7 prot", 1'b1, 3'd7, 32'h0, K_RD, 32'h0, 1'b1, 1'b0);
        access("R10 seg7 real", 1'b0, 3'd7, 32'h0, K_RD, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_order;
        load(3'd2, 16'h0040, 32'h4000_0000, 20'hFFFFF, A_G | A_PERM);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd2; ld_sel = 16'h0048; ld_base = 32'h5000_0000;
        ld_limit = 20'hFFFFF; ld_attr = A_G | A_PERM;
        req_valid = 1'b1; prot_mode = 1'b1; req_seg = 3'd2; req_off = 32'h10; req_kind = K_RD;
        @(negedge clk);
        ld_valid = 1'b0; req_valid = 1'b0;
        check("R11 same-edge old base", lin_addr, 32'h4000_0010);
        access("R11 next uses new base", 1'b1, 3'd2, 32'h10, K_RD, 32'h5000_0010, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latency;
        t_prot_addr;
        t_real;
        t_gran;
        t_down;
        t_readonly;
        t_code;
        t_kind;
        t_badseg;
        t_order;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule